// File: doc/BRIEF.md
# Pipelined SPI ADC Channel Scanner

This block drives an eight-input successive-approximation converter over a 16-bit full-duplex SPI link in clock mode 0. Every transfer carries a configuration word naming the channel to convert next while the converter shifts back a result. The converter returns a result two commands after the command that asked for it. The scanner therefore always requests two channels ahead and puts the returned data back into channel order.

After reset the block sends three transfers on its own and discards what comes back. The first is an initial configuration with the sequencer off. The next two request channel 0 and then channel 1, which fills the pipeline. Each pulse on the frame start input then runs one scan of eight transfers. Results are paired: the even channel goes in the low half of a 32-bit word and the odd channel in the high half. A one-cycle valid qualifies each of the four words of a frame.

A start pulse that arrives while a scan or the start-up sequence is running is held, and its scan begins once the current work is done.

Top module: `adc_scan_spi`

## Requirements
- R1: While reset is held, chip select is high, the serial clock is low and the result valid is low.
- R2: Each transfer holds chip select low for exactly 16 rising serial-clock edges, MSB first. The serial clock idles low, MOSI changes only on falling edges, and chip select returns high between transfers.
- R3: Every configuration word equals 0xF120 with the 3-bit channel number ORed into bits 11:9.
- R4: After reset, without any frame start, the block sends exactly three transfers: 0xF120, 0xF120, then 0xF320. It produces no result word for any of them.
- R5: During scan transfer k (k = 0..7) the configuration word requests channel (k+2) mod 8.
- R6: The data received in scan transfer k is the result of channel k, which is the result of the command sent two transfers earlier.
- R7: Each scan yields four words in channel order (0/1, 2/3, 4/5, 6/7). Within a word, the even channel sits in bits 15:0 and the odd channel in bits 31:16.
- R8: The result valid is high for exactly one clock cycle per packed word.
- R9: A frame start that arrives during a scan or during the start-up sequence is held, and one further scan runs afterwards. Several starts during one scan produce only one further scan.
- R10: With no frame start pending, the block makes no transfers and chip select stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Pulse that requests one eight-channel scan |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Converter chip select, active low |
| spi_mosi | output | 1 | Configuration data to converter |
| spi_miso | input | 1 | Conversion data from converter |
| res_valid | output | 1 | One-cycle qualifier for res_data |
| res_data | output | 32 | Two packed 16-bit results |

## Verification
The converter model tags each result with its channel and with a seed value. The bench changes the seed between scans, so the channel 0 and 1 results of a scan must carry the previous scan's seed. A design that ignored the two-command lag, or that re-requested those channels within the scan, would return the wrong seed or the wrong channel.

The full command stream is compared word by word, starting with the start-up priming. A wrong priming order or a wrong (k+2) wraparound shows up as a command mismatch. It also misaligns every later word.

Start pulses are sent during a scan and during priming. A design that dropped a held start would emit too few words. One that counted every pulse would emit extra scans.

// File: rtl/adc_scan_spi.sv
module adc_scan_spi #(
  parameter int          HALF_DIV = 2,
  parameter logic [15:0] CFG_BASE = 16'hF120,
  parameter int          CH_LSB   = 9,
  parameter int          NCH      = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_start,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        res_valid,
  output logic [31:0] res_data
);
  localparam int CHW  = $clog2(NCH);
  localparam int DIVW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  typedef enum logic [1:0] {IDLE, XFER, GAP} st_t;

  st_t            st;
  logic [DIVW-1:0] div;
  logic [15:0]    tx_sr, rx_sr, lo_half;
  logic [4:0]     nbits;
  logic [CHW-1:0] step;
  logic           priming, pend;

  wire tick         = (div == DIVW'(HALF_DIV - 1));
  wire last_step    = priming ? (step == CHW'(2)) : (step == CHW'(NCH - 1));
  wire launch_frame = (st == IDLE) && !priming && (pend || frame_start);

  assign spi_mosi = tx_sr[15];

  function automatic logic [15:0] cfg_word(input logic prime, input logic [CHW-1:0] s);
    logic [CHW-1:0] ch;
    if (prime) ch = (s == CHW'(2)) ? CHW'(1) : CHW'(0);
    else       ch = s + CHW'(2);
    return CFG_BASE | (16'(ch) << CH_LSB);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      div       <= '0;
      spi_sclk  <= 1'b0;
      spi_cs_n  <= 1'b1;
      tx_sr     <= '0;
      rx_sr     <= '0;
      lo_half   <= '0;
      nbits     <= '0;
      step      <= '0;
      priming   <= 1'b1;
      pend      <= 1'b0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= 1'b0;
      pend      <= (pend | frame_start) & ~launch_frame;
      case (st)
        IDLE: begin
          if (priming || pend || frame_start) begin
            st       <= XFER;
            spi_cs_n <= 1'b0;
            tx_sr    <= cfg_word(priming, step);
            div      <= '0;
            nbits    <= '0;
          end
        end
        XFER: begin
          if (tick) begin
            div <= '0;
            if (!spi_sclk) begin
              spi_sclk <= 1'b1;
              rx_sr    <= {rx_sr[14:0], spi_miso};
              nbits    <= nbits + 5'd1;
            end else begin
              spi_sclk <= 1'b0;
              if (nbits == 5'd16) begin
                spi_cs_n <= 1'b1;
                st       <= GAP;
                if (!priming) begin
                  if (!step[0]) lo_half <= rx_sr;
                  else begin
                    res_data  <= {rx_sr, lo_half};
                    res_valid <= 1'b1;
                  end
                end
              end else begin
                tx_sr <= {tx_sr[14:0], 1'b0};
              end
            end
          end else begin
            div <= div + DIVW'(1);
          end
        end
        default: begin
          if (tick) begin
            div <= '0;
            if (last_step) begin
              step    <= '0;
              priming <= 1'b0;
              st      <= IDLE;
            end else begin
              step     <= step + CHW'(1);
              tx_sr    <= cfg_word(priming, step + CHW'(1));
              spi_cs_n <= 1'b0;
              nbits    <= '0;
              st       <= XFER;
            end
          end else begin
            div <= div + DIVW'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/adc_scan_spi_chk.sv
module adc_scan_spi_chk (
  input logic clk,
  input logic rst_n,
  input logic spi_sclk,
  input logic spi_cs_n,
  input logic spi_mosi,
  input logic res_valid
);
  logic       sclk_q;
  logic [5:0] rises;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      rises  <= '0;
    end else begin
      sclk_q <= spi_sclk;
      if (spi_cs_n)              rises <= '0;
      else if (spi_sclk && !sclk_q) rises <= rises + 6'd1;
    end
  end

  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  // R2
  bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> rises == 6'd16);

  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && !$past(spi_cs_n) && !$fell(spi_sclk)) |-> $stable(spi_mosi));

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
endmodule

bind adc_scan_spi adc_scan_spi_chk u_chk (
  .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
  .spi_mosi(spi_mosi), .res_valid(res_valid)
);

// File: tb/sim_adc_scan_spi.sv
module sim_adc_scan_spi;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 4;
  localparam int LIMIT = 150000;
  localparam logic [15:0] INIT_SEED = 16'h1234;
  localparam logic [15:0] SEEDS [NF] = '{16'h8001, 16'h4C3A, 16'hFFFF, 16'h0000};

  logic clk = 1'b0;
  logic rst_n;
  logic frame_start;
  logic spi_sclk, spi_cs_n, spi_mosi, spi_miso;
  logic res_valid;
  logic [31:0] res_data;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_scan_spi u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .res_valid(res_valid), .res_data(res_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] chval(input logic [15:0] seed, input logic [2:0] c);
    return seed ^ {4{1'b0, c}};
  endfunction

  function automatic logic [15:0] exp_cmd(input int k);
    logic [2:0] ch;
    if (k == 0 || k == 1) return 16'hF120;
    if (k == 2) return 16'hF320;
    ch = 3'((k - 3) % 8 + 2);
    return 16'hF120 | (16'(ch) << 9);
  endfunction

  // converter model
  logic [15:0] cur_seed;
  logic [15:0] cmd_sr, res_new, res_old;
  int nrise, ncmd;

  assign spi_miso = (nrise < 16) ? res_old[15 - nrise] : 1'b0;

  always @(posedge spi_sclk or negedge spi_cs_n) begin
    if (spi_sclk) begin
      cmd_sr = {cmd_sr[14:0], spi_mosi};
      nrise++;
    end else begin
      cmd_sr = '0;
      nrise  = 0;
    end
  end

  always @(posedge spi_cs_n or negedge rst_n) begin
    if (!rst_n) begin
      ncmd = 0; res_new = '0; res_old = '0;
    end else begin
      chk(nrise == 16, "R2 bits per transfer", 32'(nrise), 32'd16);
      chk(cmd_sr == exp_cmd(ncmd), "R3/R4/R5 command word", {16'h0, cmd_sr}, {16'h0, exp_cmd(ncmd)});
      res_old = res_new;
      res_new = chval(cur_seed, cmd_sr[11:9]);
      ncmd++;
    end
  end

  // result collector
  logic [31:0] got [64];
  int nw;
  logic prev_v;
  always @(negedge clk) begin
    if (!rst_n) begin
      nw = 0; prev_v = 1'b0;
    end else begin
      if (res_valid) begin
        chk(!prev_v, "R8 single-cycle valid", 32'(prev_v), 32'd0);
        if (nw < 64) got[nw] = res_data;
        nw++;
      end
      prev_v = res_valid;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= LIMIT) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
  endtask

  task automatic wait_words(input int n);
    while (nw < n) @(negedge clk);
  endtask

  task automatic check_frame(input int base, input logic [15:0] prv, input logic [15:0] cur, input string tag);
    for (int w = 0; w < 4; w++) begin
      logic [15:0] lo, hi;
      lo = (w == 0) ? chval(prv, 3'd0) : chval(cur, 3'(2*w));
      hi = (w == 0) ? chval(prv, 3'd1) : chval(cur, 3'(2*w + 1));
      chk(got[base + w] == {hi, lo}, tag, got[base + w], {hi, lo});
    end
  endtask

  initial begin
    rst_n = 1'b0;
    frame_start = 1'b0;
    cur_seed = INIT_SEED;
    wait_cycles(4);
    chk(spi_cs_n == 1'b1, "R1 cs_n in reset", 32'(spi_cs_n), 32'd1);
    chk(spi_sclk == 1'b0, "R1 sclk in reset", 32'(spi_sclk), 32'd0);
    chk(res_valid == 1'b0, "R1 valid in reset", 32'(res_valid), 32'd0);
    rst_n = 1'b1;

    wait_cycles(400);
    chk(ncmd == 3, "R4 priming transfers", 32'(ncmd), 32'd3);
    chk(nw == 0, "R4 no output while priming", 32'(nw), 32'd0);
    chk(spi_cs_n == 1'b1, "R10 idle cs_n", 32'(spi_cs_n), 32'd1);
    wait_cycles(300);
    chk(ncmd == 3, "R10 no transfers while idle", 32'(ncmd), 32'd3);

    // table-driven scans: R6 lag, R7 packing and order
    for (int f = 0; f < NF; f++) begin
      logic [15:0] prv;
      prv = (f == 0) ? INIT_SEED : SEEDS[f - 1];
      cur_seed = SEEDS[f];
      pulse_start();
      wait_words(4 * (f + 1));
      wait_cycles(20);
      check_frame(4 * f, prv, SEEDS[f], "R6/R7 scan words");
    end
    chk(nw == 4 * NF, "R7 four words per scan", 32'(nw), 32'(4 * NF));
    chk(ncmd == 3 + 8 * NF, "R5 eight transfers per scan", 32'(ncmd), 32'(3 + 8 * NF));

    // R9: starts during a scan are held and collapse to one
    cur_seed = 16'h5A5A;
    pulse_start();
    wait_cycles(100);
    pulse_start();
    wait_cycles(100);
    pulse_start();
    wait_cycles(1500);
    chk(nw == 4 * NF + 8, "R9 held start runs one extra scan", 32'(nw), 32'(4 * NF + 8));
    chk(ncmd == 3 + 8 * NF + 16, "R9 transfer count", 32'(ncmd), 32'(3 + 8 * NF + 16));
    check_frame(4 * NF, SEEDS[NF - 1], 16'h5A5A, "R9 first scan words");
    check_frame(4 * NF + 4, 16'h5A5A, 16'h5A5A, "R9 held scan words");

    // R9: start during priming
    cur_seed = 16'h0F0F;
    rst_n = 1'b0;
    wait_cycles(3);
    rst_n = 1'b1;
    wait_cycles(5);
    pulse_start();
    wait_cycles(1200);
    chk(nw == 4, "R9 start during priming", 32'(nw), 32'd4);
    chk(ncmd == 11, "R4 priming then scan", 32'(ncmd), 32'd11);
    check_frame(0, 16'h0F0F, 16'h0F0F, "R9 scan after priming");
    chk(spi_cs_n == 1'b1, "R10 idle after scan", 32'(spi_cs_n), 32'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule